// File: doc/BRIEF.md
# Serial Memory Byte Engine with Burst Loader

This block sits between a host register port and a byte-wide external nonvolatile memory. Through four small registers the host can ask for one byte to be fetched from a chosen location into a data register, or ask for the low byte of that data register to be stored at a chosen location. Each request is a bit in a control register that the engine clears by itself once the memory acknowledges the transfer.

The same control register also starts a burst load. In this mode the engine reads three-byte records from the external memory and writes each one into a 24-bit internal address space. A record holds a target offset (low byte, then high byte) and a data byte. The engine places the top nine bits of each target address from a base register and takes the low fifteen bits from the record. A record offset of 0xFFFF ends the burst. The burst starts at external address 0 if no transfer has happened since reset. Otherwise it continues from the location after the last byte the engine touched.

Top module: `eeprom_loader`

## Requirements
- R1: After reset all four registers read 0 (control at index 0, address at 1, data at 2, base at 3), and ee_req and mem_we are low.
- R2: Writing the control register with bit 1 set starts a single read. Bit 1 reads 1 until the memory acknowledges, then reads 0, and the data register then holds the byte stored at the address register's location.
- R3: Writing the control register with bit 0 set stores data register bits [7:0] at the address register's location. Bit 0 reads 1 until the acknowledge arrives, then reads 0.
- R4: Writing the control register with bit 2 set starts a burst. Bit 2 reads 1 until the terminating record is read, and the engine issues no memory write strobe on the external side during the burst.
- R5: A burst reads from an internal next-address pointer. Reset sets the pointer to 0. A single access sets it to the accessed address plus 1, and each byte read in a burst adds 1 to it, including both bytes of the terminator.
- R6: Each burst record produces one internal write at address {base[8:0], offset[14:0]}. Bit 15 of the offset is ignored.
- R7: A burst record is read as offset low byte, offset high byte, then data byte. Each record produces exactly one single-cycle mem_we pulse, and a 0xFFFF offset produces no write and ends the burst.
- R8: Control bit 3 reads 1 while any request or burst is in progress. While it is 1, every register write is ignored, including new requests.
- R9: When one control write sets more than one request bit, only one request runs. Read wins over write, and write wins over burst.
- R10: ee_req stays high with ee_addr, ee_we and ee_wdata unchanged until a one-cycle ee_ack, and each ee_ack completes exactly one byte transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| ee_req | output | 1 | External byte transfer request |
| ee_we | output | 1 | 1 = store byte, 0 = fetch byte |
| ee_addr | output | 16 | External byte address |
| ee_wdata | output | 8 | Byte to store |
| ee_ack | input | 1 | One-cycle transfer acknowledge |
| ee_rdata | input | 8 | Fetched byte, valid with ee_ack |
| mem_we | output | 1 | Internal memory write strobe |
| mem_addr | output | 24 | Internal memory write address |
| mem_wdata | output | 8 | Internal memory write data |

## Verification
The hardest case to reach from the ports is a burst that resumes from a pointer left by earlier traffic. The stimulus runs a burst straight after reset, then a second burst that must continue after the first terminator, then single accesses followed by a third burst that must start one past the last single address. Records with offset bit 15 set and a changed base register check the address build. Conflicting multi-bit control writes, and writes issued while a slow acknowledge is still pending, check the priority and ignore rules.

// File: rtl/eel_pkg.sv
package eel_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_BLO,
        ST_BHI,
        ST_BDAT
    } eel_state_e;

    localparam logic [1:0] IDX_CTRL = 2'd0;
    localparam logic [1:0] IDX_ADDR = 2'd1;
    localparam logic [1:0] IDX_DATA = 2'd2;
    localparam logic [1:0] IDX_BASE = 2'd3;

    localparam int CB_WR    = 0;
    localparam int CB_RD    = 1;
    localparam int CB_BURST = 2;
endpackage

// File: rtl/eel_regs.sv
module eel_regs #(
    parameter int EE_AW  = 16,
    parameter int DW     = 8,
    parameter int BASE_W = 9,
    parameter int RW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        widx,
    input  logic [RW-1:0]     wdata,
    input  logic              busy,
    input  logic              ld,
    input  logic [DW-1:0]     ld_val,
    output logic [EE_AW-1:0]  addr_q,
    output logic [DW-1:0]     data_q,
    output logic [BASE_W-1:0] base_q
);
    import eel_pkg::*;

    typedef struct packed {
        logic [EE_AW-1:0]  addr;
        logic [DW-1:0]     data;
        logic [BASE_W-1:0] base;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ok;

    assign wr_ok = wr && !busy;

    always_comb begin
        r_d = r_q;
        if (wr_ok) begin
            case (widx)
                IDX_ADDR: r_d.addr = wdata[EE_AW-1:0];
                IDX_DATA: r_d.data = wdata[DW-1:0];
                IDX_BASE: r_d.base = wdata[BASE_W-1:0];
                default:  ;
            endcase
        end
        if (ld) r_d.data = ld_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign addr_q = r_q.addr;
    assign data_q = r_q.data;
    assign base_q = r_q.base;
endmodule

// File: rtl/eel_engine.sv
module eel_engine #(
    parameter int EE_AW  = 16,
    parameter int DW     = 8,
    parameter int MEM_AW = 24,
    parameter int BASE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [2:0]        ctrl_bits,
    input  logic [EE_AW-1:0]  addr_q,
    input  logic [DW-1:0]     data_q,
    input  logic [BASE_W-1:0] base_q,
    input  logic              ee_ack,
    input  logic [DW-1:0]     ee_rdata,
    output logic              busy,
    output logic [2:0]        pend,
    output logic              data_ld,
    output logic              ee_req,
    output logic              ee_we,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [DW-1:0]     ee_wdata,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata
);
    import eel_pkg::*;

    localparam int OFS_W = EE_AW - 1;

    typedef struct packed {
        eel_state_e        st;
        logic [EE_AW-1:0]  ptr;
        logic [EE_AW-1:0]  rec;
        logic              mwe;
        logic [MEM_AW-1:0] maddr;
        logic [DW-1:0]     mdata;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        e_d     = e_q;
        e_d.mwe = 1'b0;
        case (e_q.st)
            ST_IDLE: begin
                if (ctrl_wr) begin
                    if (ctrl_bits[CB_RD])         e_d.st = ST_RD;
                    else if (ctrl_bits[CB_WR])    e_d.st = ST_WR;
                    else if (ctrl_bits[CB_BURST]) e_d.st = ST_BLO;
                end
            end
            ST_RD, ST_WR: begin
                if (ee_ack) begin
                    e_d.st  = ST_IDLE;
                    e_d.ptr = addr_q + 1'b1;
                end
            end
            ST_BLO: begin
                if (ee_ack) begin
                    e_d.rec[DW-1:0] = ee_rdata;
                    e_d.ptr         = e_q.ptr + 1'b1;
                    e_d.st          = ST_BHI;
                end
            end
            ST_BHI: begin
                if (ee_ack) begin
                    e_d.ptr             = e_q.ptr + 1'b1;
                    e_d.rec[EE_AW-1:DW] = ee_rdata;
                    if ({ee_rdata, e_q.rec[DW-1:0]} == {EE_AW{1'b1}}) e_d.st = ST_IDLE;
                    else                                             e_d.st = ST_BDAT;
                end
            end
            ST_BDAT: begin
                if (ee_ack) begin
                    e_d.ptr   = e_q.ptr + 1'b1;
                    e_d.mwe   = 1'b1;
                    e_d.maddr = {base_q, e_q.rec[OFS_W-1:0]};
                    e_d.mdata = ee_rdata;
                    e_d.st    = ST_BLO;
                end
            end
            default: e_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{st: ST_IDLE, default: '0};
        else        e_q <= e_d;
    end

    assign busy             = (e_q.st != ST_IDLE);
    assign pend[CB_RD]      = (e_q.st == ST_RD);
    assign pend[CB_WR]      = (e_q.st == ST_WR);
    assign pend[CB_BURST]   = (e_q.st == ST_BLO) || (e_q.st == ST_BHI) || (e_q.st == ST_BDAT);
    assign data_ld          = (e_q.st == ST_RD) && ee_ack;
    assign ee_req           = busy;
    assign ee_we            = (e_q.st == ST_WR);
    assign ee_addr          = (pend[CB_RD] || pend[CB_WR]) ? addr_q : e_q.ptr;
    assign ee_wdata         = data_q;
    assign mem_we           = e_q.mwe;
    assign mem_addr         = e_q.maddr;
    assign mem_wdata        = e_q.mdata;
endmodule

// File: rtl/eeprom_loader.sv
module eeprom_loader #(
    parameter int EE_AW  = 16,
    parameter int DW     = 8,
    parameter int MEM_AW = 24,
    parameter int RW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [RW-1:0]     reg_wdata,
    output logic [RW-1:0]     reg_rdata,
    output logic              ee_req,
    output logic              ee_we,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [DW-1:0]     ee_wdata,
    input  logic              ee_ack,
    input  logic [DW-1:0]     ee_rdata,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata
);
    import eel_pkg::*;

    localparam int BASE_W = MEM_AW - (EE_AW - 1);

    logic              busy;
    logic [2:0]        pend;
    logic              data_ld;
    logic [EE_AW-1:0]  addr_q;
    logic [DW-1:0]     data_q;
    logic [BASE_W-1:0] base_q;
    logic              ctrl_wr;

    assign ctrl_wr = reg_wr && (reg_addr == IDX_CTRL);

    eel_regs #(.EE_AW(EE_AW), .DW(DW), .BASE_W(BASE_W), .RW(RW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .widx   (reg_addr),
        .wdata  (reg_wdata),
        .busy   (busy),
        .ld     (data_ld),
        .ld_val (ee_rdata),
        .addr_q (addr_q),
        .data_q (data_q),
        .base_q (base_q)
    );

    eel_engine #(.EE_AW(EE_AW), .DW(DW), .MEM_AW(MEM_AW), .BASE_W(BASE_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_bits (reg_wdata[2:0]),
        .addr_q    (addr_q),
        .data_q    (data_q),
        .base_q    (base_q),
        .ee_ack    (ee_ack),
        .ee_rdata  (ee_rdata),
        .busy      (busy),
        .pend      (pend),
        .data_ld   (data_ld),
        .ee_req    (ee_req),
        .ee_we     (ee_we),
        .ee_addr   (ee_addr),
        .ee_wdata  (ee_wdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            IDX_CTRL: reg_rdata[3:0]        = {busy, pend};
            IDX_ADDR: reg_rdata[EE_AW-1:0]  = addr_q;
            IDX_DATA: reg_rdata[DW-1:0]     = data_q;
            default:  reg_rdata[BASE_W-1:0] = base_q;
        endcase
    end
endmodule

// File: rtl/eel_chk.sv
module eel_chk #(
    parameter int EE_AW  = 16,
    parameter int DW     = 8,
    parameter int MEM_AW = 24,
    parameter int BASE_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ee_req,
    input logic              ee_ack,
    input logic              ee_we,
    input logic [EE_AW-1:0]  ee_addr,
    input logic [DW-1:0]     ee_wdata,
    input logic              mem_we,
    input logic [MEM_AW-1:0] mem_addr,
    input logic [BASE_W-1:0] base_q,
    input logic              busy,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [EE_AW-1:0]  addr_q,
    input logic              burst_bit
);
    import eel_pkg::*;

    assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata)));

    assert_mem_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(ee_ack) && !$past(ee_we)));

    assert_mem_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    assert_mem_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[MEM_AW-1:EE_AW-1] == base_q));

    assert_ignore_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == IDX_ADDR) |=> $stable(addr_q));

    assert_burst_no_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        burst_bit |-> !ee_we);
endmodule

bind eeprom_loader eel_chk #(.EE_AW(EE_AW), .DW(DW), .MEM_AW(MEM_AW), .BASE_W(BASE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ee_req    (ee_req),
    .ee_ack    (ee_ack),
    .ee_we     (ee_we),
    .ee_addr   (ee_addr),
    .ee_wdata  (ee_wdata),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .base_q    (base_q),
    .busy      (busy),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .addr_q    (addr_q),
    .burst_bit (pend[2])
);

// File: tb/sim_eeprom_loader.sv
`timescale 1ns/1ps
module sim_eeprom_loader;
    localparam int LAT = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0;
    logic [1:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic        ee_req, ee_we;
    logic [15:0] ee_addr;
    logic [7:0]  ee_wdata;
    logic        ee_ack = 0;
    logic [7:0]  ee_rdata = 0;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;

    int vectors = 0;
    int fails = 0;
    int acks = 0;
    int cnt = 0;
    bit done = 0;
    logic [7:0]  rom [256];
    logic [31:0] exp_q [$];

    always #2.5 clk = ~clk;

    eeprom_loader u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // external memory model: acknowledges after LAT request cycles
    always @(negedge clk) begin
        if (!rst_n || !ee_req) begin
            ee_ack = 0;
            cnt = 0;
        end else if (cnt == LAT - 1) begin
            ee_ack = 1;
            ee_rdata = rom[ee_addr[7:0]];
            if (ee_we) rom[ee_addr[7:0]] = ee_wdata;
            cnt = 0;
            acks++;
        end else begin
            ee_ack = 0;
            cnt++;
        end
    end

    // scoreboard monitor for internal writes
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                chk(0, "R7 unexpected write", {mem_addr, mem_wdata}, 0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk({mem_addr, mem_wdata} == e, "R6/R7 write", {mem_addr, mem_wdata}, e);
            end
        end
    end

    task automatic wreg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 400; i++) begin
            rreg(2'd0, v);
            if (!v[3]) return;
        end
        chk(0, "R8 busy never cleared", 1, 0);
    endtask

    task automatic put_rec(input int a, input logic [15:0] ofs, input logic [7:0] d);
        rom[a] = ofs[7:0]; rom[a+1] = ofs[15:8]; rom[a+2] = d;
    endtask

    task automatic expect_wr(input logic [8:0] base, input logic [15:0] ofs, input logic [7:0] d);
        exp_q.push_back({base, ofs[14:0], d});
    endtask

    initial begin
        logic [15:0] v;
        int a0;
        for (int i = 0; i < 256; i++) rom[i] = 8'(i ^ 8'h5C);
        repeat (3) @(negedge clk);
        chk(ee_req == 0 && mem_we == 0, "R1 outputs idle", {ee_req, mem_we}, 0);
        rst_n = 1;
        for (int i = 0; i < 4; i++) begin
            rreg(2'(i), v);
            chk(v == 0, "R1 reset register", v, 0);
        end

        // burst straight after reset: starts at 0 (R5)
        put_rec(0, 16'h0010, 8'hA5);
        put_rec(3, 16'h8023, 8'h5A);
        rom[6] = 8'hFF; rom[7] = 8'hFF;
        wreg(2'd3, 16'h01AB);
        expect_wr(9'h1AB, 16'h0010, 8'hA5);
        expect_wr(9'h1AB, 16'h8023, 8'h5A);
        wreg(2'd0, 16'h0004);
        rreg(2'd0, v);
        chk(v[3:0] == 4'hC, "R4 R8 burst pending and busy", v, 16'hC);
        wreg(2'd1, 16'h0055);
        wait_idle();
        rreg(2'd0, v);
        chk(v == 0, "R4 burst bit self clears", v, 0);
        chk(exp_q.size() == 0, "R7 all records written", exp_q.size(), 0);
        rreg(2'd1, v);
        chk(v == 0, "R8 address write ignored while busy", v, 0);

        // second burst resumes after terminator at 8 (R5)
        put_rec(8, 16'h0042, 8'h3C);
        rom[11] = 8'hFF; rom[12] = 8'hFF;
        expect_wr(9'h1AB, 16'h0042, 8'h3C);
        wreg(2'd0, 16'h0004);
        wait_idle();
        chk(exp_q.size() == 0, "R5 burst resumes after previous", exp_q.size(), 0);

        // single read (R2) with ignored requests while busy (R8)
        rom[8'h30] = 8'h9E;
        wreg(2'd1, 16'h0030);
        a0 = acks;
        wreg(2'd0, 16'h0002);
        rreg(2'd0, v);
        chk(v[3:0] == 4'hA, "R2 read pending", v, 16'hA);
        wreg(2'd0, 16'h0004);
        wait_idle();
        rreg(2'd2, v);
        chk(v == 16'h009E, "R2 read data", v, 16'h9E);
        chk(acks - a0 == 1, "R10 one transfer per read", acks - a0, 1);
        repeat (30) @(negedge clk);
        rreg(2'd0, v);
        chk(v == 0 && exp_q.size() == 0, "R8 burst request ignored while busy", v, 0);

        // single write (R3)
        wreg(2'd2, 16'h01C7);
        rreg(2'd2, v);
        chk(v == 16'h00C7, "R3 data keeps low byte", v, 16'hC7);
        wreg(2'd1, 16'h0040);
        wreg(2'd0, 16'h0001);
        rreg(2'd0, v);
        chk(v[3:0] == 4'h9, "R3 write pending", v, 16'h9);
        wait_idle();
        chk(rom[8'h40] == 8'hC7, "R3 byte stored", rom[8'h40], 8'hC7);

        // burst after single access starts at 0x41 (R5), new base (R6)
        put_rec(8'h41, 16'h7FFF, 8'h11);
        rom[8'h44] = 8'hFF; rom[8'h45] = 8'hFF;
        wreg(2'd3, 16'h0003);
        expect_wr(9'h003, 16'h7FFF, 8'h11);
        wreg(2'd0, 16'h0004);
        wait_idle();
        chk(exp_q.size() == 0, "R5 R6 burst after single access", exp_q.size(), 0);

        // priority (R9): read beats write and burst
        rom[8'h50] = 8'h77;
        wreg(2'd1, 16'h0050);
        wreg(2'd2, 16'h0000);
        wreg(2'd0, 16'h0007);
        wait_idle();
        rreg(2'd2, v);
        chk(v == 16'h0077, "R9 read wins", v, 16'h77);
        chk(rom[8'h50] == 8'h77, "R9 no store on read win", rom[8'h50], 8'h77);
        // write beats burst
        rom[8'h51] = 8'h00;
        wreg(2'd1, 16'h0051);
        wreg(2'd0, 16'h0005);
        wait_idle();
        chk(rom[8'h51] == 8'h77, "R9 write wins over burst", rom[8'h51], 8'h77);
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R9 no burst ran", exp_q.size(), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule